// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Page Programming

This block is a two-wire serial bus slave in front of an internal byte-wide memory of 256, 512, 1024 or 2048 bytes, chosen by a parameter. A fast system clock samples the bus clock and data lines. The block finds bus conditions in that sampled stream and pulls the data line low when it acknowledges or sends a zero bit. A host can write one byte or a page of bytes, read from the current pointer, read from any address it chooses, and stream reads across the whole array.

Written bytes first collect in a page buffer. A STOP commits them to the array in one program cycle of fixed length. While that cycle runs, the slave does not answer its device address, so a host can poll for completion. A write-protect input and a supply-lockout input each refuse writes: the slave declines the first data byte and programs nothing.

Top module: `i2c_mem_slave`

## Requirements
- R1: Before a START (data falling while clock is high) all bus traffic is ignored and no acknowledge is given. A STOP (data rising while clock is high) releases the data line and returns the slave to idle.
- R2: The device byte is 1010 in bits 7..4, three address bits in bits 3..1 and the direction in bit 0 (1 = read, 0 = write). A byte with any other value in bits 7..4 is not acknowledged.
- R3: Device-byte bits 3..1 supply memory-address bits 10..8, and only as many of them as the density needs: none at 256 bytes, bit 8 only at 512, bits 9..8 at 1024, all three at 2048. Unused bits are don't care.
- R4: In a write, the byte after the device byte is the low 8 address bits. The device byte, the address byte and each accepted data byte are acknowledged on the 9th clock. A single data byte is stored at that address.
- R5: In a page write, successive data bytes go to successive addresses within a 16-byte page. The low 4 bits wrap and the upper bits stay fixed. The bytes are committed to the array only after STOP.
- R6: The pointer holds the last address accessed plus one. A read with no address phase returns the byte at the pointer. Reads wrap from the top address to 0.
- R7: A read continues byte by byte while the master acknowledges, incrementing across all address bits. After a master not-acknowledge the slave releases the line and waits for the next START or STOP.
- R8: A write of the address only, then a repeated START with the read bit set, returns data from that address.
- R9: With write protect high, the device and address bytes are acknowledged, the first data byte is not, nothing is programmed and no program cycle starts.
- R10: With supply lockout high, writes are refused exactly as in R9.
- R11: A program cycle lasts PROG_CYCLES clock cycles from its start after STOP. During it the device byte is not acknowledged.
- R12: The data-line drive comes from a register and changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| wp_i | input | 1 | Write protect, high refuses writes |
| lockout_i | input | 1 | Supply below threshold, high refuses writes |
| sda_low_o | output | 1 | Pull the data line low when high (open-drain enable) |

## Verification
The bench builds the block at 2048 bytes, a 16-byte page and a 300-cycle program time. At this density all three device-byte address bits are live, so bytes at the same low address in different 256-byte blocks can be told apart. A single read from address 2047 reaches the top-to-zero wrap. The short program time lets acknowledge polling run many times, including an immediate poll that must be refused, within a brief run.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK
  } state_t;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edge while the clock stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_ram.sv
module i2cm_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
  parameter int AW          = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 4000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          clear,
  input  logic          commit,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  logic [7:0]         buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [AW-PW-1:0]   page_q;
  logic [CW-1:0]      cnt;
  logic [PW-1:0]      idx;

  assign idx = cnt[PW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && !busy) buf_q[wr_addr[PW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      valid     <= '0;
      page_q    <= '0;
      cnt       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        if (cnt < CW'(PAGE_BYTES) && valid[idx]) begin
          mem_we    <= 1'b1;
          mem_addr  <= {page_q, idx};
          mem_wdata <= buf_q[idx];
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(PROG_CYCLES - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else if (commit && |valid) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (clear) begin
        valid <= '0;
      end else if (wr_en) begin
        valid[wr_addr[PW-1:0]] <= 1'b1;
        page_q <= wr_addr[AW-1:PW];
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic lockout_i,
  output logic sda_low_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  state_t st, nxt_st;
  logic [3:0]    bitcnt;
  logic [7:0]    sh, tx, rd_data;
  logic [2:0]    hi_q;
  logic [AW-1:0] addr;
  logic          mack;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          rx_phase, byte_done, dev_done, data_done, blocked, dev_hit;
  logic          pb_wr, pb_clear;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_phase  = (st == ST_DEV) || (st == ST_WADDR) || (st == ST_WDATA);
  assign byte_done = rx_phase && scl_fall && (bitcnt == 4'd8);
  assign dev_done  = byte_done && (st == ST_DEV);
  assign data_done = byte_done && (st == ST_WDATA);
  assign blocked   = wp_i | lockout_i;
  assign dev_hit   = (sh[7:4] == DEV_TAG) && !busy;
  assign pb_wr     = data_done && !blocked;
  assign pb_clear  = start_det || (data_done && blocked);

  i2cm_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_page (
    .clk(clk), .rst(rst), .wr_en(pb_wr), .wr_addr(addr), .wr_data(sh),
    .clear(pb_clear), .commit(stop_det), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  i2cm_ram #(.DEPTH(MEM_BYTES)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      nxt_st    <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      hi_q      <= '0;
      addr      <= '0;
      mack      <= 1'b0;
      sda_low_o <= 1'b0;
    end else if (start_det) begin
      st        <= ST_DEV;
      bitcnt    <= '0;
      sda_low_o <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      sda_low_o <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (dev_hit) begin
                sda_low_o <= 1'b1;
                st        <= ST_ACK;
                hi_q      <= sh[3:1];
                addr      <= AW'({sh[3:1], addr[7:0]});
                nxt_st    <= sh[0] ? ST_RDATA : ST_WADDR;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              sda_low_o <= 1'b1;
              st        <= ST_ACK;
              addr      <= AW'({hi_q, sh});
              nxt_st    <= ST_WDATA;
            end else if (blocked) begin
              st <= ST_IDLE;
            end else begin
              sda_low_o <= 1'b1;
              st        <= ST_ACK;
              nxt_st    <= ST_WDATA;
              addr      <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            st     <= nxt_st;
            if (nxt_st == ST_RDATA) begin
              tx        <= rd_data;
              sda_low_o <= ~rd_data[7];
              addr      <= addr + 1'b1;
            end else begin
              sda_low_o <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_low_o <= 1'b0;
              bitcnt    <= '0;
              st        <= ST_MACK;
            end else begin
              tx        <= {tx[6:0], 1'b0};
              sda_low_o <= ~tx[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx        <= rd_data;
              sda_low_o <= ~rd_data[7];
              addr      <= addr + 1'b1;
              st        <= ST_RDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int PROG_CYCLES = 4000
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_low_o,
  input logic stop_det,
  input logic dev_done,
  input logic data_done,
  input logic wp_i,
  input logic lockout_i,
  input logic busy,
  input logic mem_we
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_low_o);

  assert_busy_nack_R11: assert property (@(posedge clk) disable iff (rst)
    (dev_done && busy) |=> !sda_low_o);

  assert_prog_length_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == PROG_CYCLES));

  assert_wp_nack_R9: assert property (@(posedge clk) disable iff (rst)
    (data_done && wp_i) |=> !sda_low_o);

  assert_lock_nack_R10: assert property (@(posedge clk) disable iff (rst)
    (data_done && lockout_i) |=> !sda_low_o);

  assert_write_in_prog_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(busy));

  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low_o) |-> !scl_i);
endmodule

bind i2c_mem_slave i2cm_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .stop_det(stop_det), .dev_done(dev_done), .data_done(data_done),
  .wp_i(wp_i), .lockout_i(lockout_i), .busy(busy), .mem_we(mem_we)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int MEM  = 2048;
  localparam int PAGE = 16;
  localparam int PROG = 300;
  localparam int Q    = 5;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0, lock = 1'b0;
  logic sda_low, sda_line;
  assign sda_line = sda_m & ~sda_low;

  i2c_mem_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .lockout_i(lock), .sda_low_o(sda_low)
  );

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  int checks = 0, errors = 0, viol = 0;
  logic [7:0]  model [MEM];
  logic [7:0]  wbuf [32];
  logic [10:0] ptr = '0;
  logic        prev_low = 1'b0;

  // R12 monitor: drive may only change while the bus clock is low
  always @(negedge clk) begin
    if (!rst && sda_low !== prev_low && scl) viol++;
    prev_low <= sda_low;
  end

  function automatic logic [10:0] page_addr(logic [10:0] base, int i);
    return {base[10:4], 4'(int'(base[3:0]) + i)};
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~give_ack);
  endtask

  task automatic poll_idle();
    logic a;
    int tries = 0;
    do begin
      bus_start();
      send_byte({4'hA, ptr[10:8], 1'b0}, a);
      bus_stop();
      tries++;
    end while (!a && tries < 100);
    chk("R11 program cycle ends", a, 1);
  endtask

  task automatic do_write(logic [2:0] hi, logic [7:0] word, int n, bit ok, string tag);
    logic a;
    logic [10:0] base = {hi, word};
    bus_start();
    send_byte({4'hA, hi, 1'b0}, a); chk({tag, " dev ack"}, a, 1);
    send_byte(word, a);             chk({tag, " word ack"}, a, 1);
    ptr = base;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      if (ok) begin
        chk({tag, " data ack"}, a, 1);
        model[page_addr(base, i)] = wbuf[i];
      end else begin
        chk({tag, " data nack"}, a, 0);
        break;
      end
    end
    if (ok) ptr = page_addr(base, n);
    bus_stop();
  endtask

  task automatic read_cur(logic [2:0] hi, int n, string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte({4'hA, hi, 1'b1}, a); chk({tag, " read dev ack"}, a, 1);
    ptr = {hi, ptr[7:0]};
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk({tag, " read data"}, b, model[ptr]);
      ptr = ptr + 1'b1;
    end
    tick(2);
    chk({tag, " R7 release after nack"}, sda_low, 0);
    bus_stop();
  endtask

  task automatic rand_read(logic [2:0] hi, logic [7:0] word, int n, string tag);
    logic a;
    bus_start();
    send_byte({4'hA, hi, 1'b0}, a); chk({tag, " dummy dev ack"}, a, 1);
    send_byte(word, a);             chk({tag, " dummy word ack"}, a, 1);
    ptr = {hi, word};
    read_cur(hi, n, tag);
  endtask

  initial begin
    logic a;
    for (int i = 0; i < MEM; i++) model[i] = 8'h00;
    void'($urandom(32'd4711));
    tick(4);
    rst = 1'b0;
    tick(2);
    chk("R12 reset releases line", sda_low, 0);

    // R1: clocked byte without START is ignored
    send_byte(8'hA0, a);
    chk("R1 no ack before START", a, 0);
    bus_stop();

    // R2: wrong tag
    bus_start();
    send_byte(8'hB0, a);
    chk("R2 wrong tag nack", a, 0);
    bus_stop();

    // R4 byte write, R11 busy polling, R6 current read
    wbuf[0] = 8'h5A;
    do_write(3'd5, 8'h3C, 1, 1'b1, "R4");
    bus_start();
    send_byte({4'hA, 3'd5, 1'b0}, a);
    chk("R11 nack while programming", a, 0);
    bus_stop();
    poll_idle();
    rand_read(3'd5, 8'h3C, 1, "R4 readback");
    read_cur(3'd5, 2, "R6 current address");

    // R5 page wrap over 18 bytes
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h80 + i);
    do_write(3'd2, 8'h1E, 18, 1'b1, "R5");
    poll_idle();
    rand_read(3'd2, 8'h10, 16, "R5 R8 page readback");

    // R6 wrap at the top address, R7 sequential crossing
    wbuf[0] = 8'hE7;
    do_write(3'd7, 8'hFF, 1, 1'b1, "R6 top");
    poll_idle();
    wbuf[0] = 8'h19;
    do_write(3'd0, 8'h00, 1, 1'b1, "R6 zero");
    poll_idle();
    rand_read(3'd7, 8'hFF, 3, "R6 R7 wrap read");

    // R3 high bits select distinct blocks
    wbuf[0] = 8'h11;
    do_write(3'd0, 8'h40, 1, 1'b1, "R3 blk0");
    poll_idle();
    wbuf[0] = 8'h33;
    do_write(3'd3, 8'h40, 1, 1'b1, "R3 blk3");
    poll_idle();
    rand_read(3'd0, 8'h40, 1, "R3 blk0 read");
    rand_read(3'd3, 8'h40, 1, "R3 blk3 read");

    // R9 write protect
    wp = 1'b1;
    wbuf[0] = 8'hC3;
    do_write(3'd3, 8'h40, 1, 1'b0, "R9");
    bus_start();
    send_byte({4'hA, 3'd3, 1'b0}, a);
    chk("R9 no program cycle", a, 1);
    bus_stop();
    wp = 1'b0;
    rand_read(3'd3, 8'h40, 1, "R9 unchanged");

    // R10 supply lockout
    lock = 1'b1;
    wbuf[0] = 8'h3C;
    do_write(3'd0, 8'h40, 1, 1'b0, "R10");
    bus_start();
    send_byte({4'hA, 3'd0, 1'b0}, a);
    chk("R10 no program cycle", a, 1);
    bus_stop();
    lock = 1'b0;
    rand_read(3'd0, 8'h40, 1, "R10 unchanged");

    // mixed random traffic
    for (int it = 0; it < 10; it++) begin
      logic [2:0] h = 3'($urandom % 8);
      logic [7:0] w = 8'($urandom % 256);
      int n = 1 + int'($urandom % 18);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(h, w, n, 1'b1, "R4 R5 random write");
      poll_idle();
      if ($urandom % 2 == 0)
        read_cur(3'($urandom % 8), 1 + int'($urandom % 8), "R6 random current");
      else
        rand_read(3'($urandom % 8), 8'($urandom), 1 + int'($urandom % 10), "R8 random read");
    end

    chk("R12 drive changed with clock high", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule